// File: doc/BRIEF.md
# Two-Register Arithmetic Data Unit

This block is a small data element for a control-driven datapath. It keeps two working registers, called A and B, and changes them when a controller issues a command. A command is a one-cycle start pulse together with a 4-bit operation code. The unit can move data between the registers, exchange data with a shared bus, and perform addition, subtraction, complement, AND, OR and one-bit shifts. Arithmetic and logic results are written back into A. Each command is acknowledged by a completion pulse.

Four condition outputs describe register A and the carry left by the last addition or subtraction. A branch element can test these outputs directly. Data arrives on a bus input. Data leaves on a bus output, which is non-zero only in the cycle in which the unit answers an output command.

The width is a parameter. A second parameter selects how the adder is built: either one shared adder with operand inversion, or separate add and subtract paths. Both variants give the same results.

Top module: `gpa_unit`

## Requirements
- R1: After reset, both registers and the carry flag are zero. `done`, `bus_out_vld` and `bus_out` are all zero, and `flag_zero` is 1.
- R2: A `start` pulse in cycle t makes `done` high in cycle t+1 only. `done` never rises without a `start` in the cycle before. A command can be issued in every cycle.
- R3: Opcode 1 copies A into B. Opcode 2 copies B into A. Opcode 3 loads A from `bus_in`. Opcode 4 loads B from `bus_in`. `bus_in` is sampled in the start cycle.
- R4: Opcode 5 (or 6) places A (or B) on `bus_out` with `bus_out_vld` high in the cycle after start. In every other cycle `bus_out` is zero and `bus_out_vld` is low.
- R5: Opcode 7 sets A to A+B modulo 2^W, and the carry flag to the carry out. Opcode 8 sets A to A-B, and the carry flag to 1 when no borrow occurs (A >= B unsigned).
- R6: Opcode 9 sets A to the bitwise complement of A. Opcode 10 sets A to A AND B. Opcode 11 sets A to A OR B.
- R7: Opcode 12 shifts A left by one and fills the low bit with 0. Opcode 13 shifts A right by one and keeps the sign bit. Opcodes 14 and 15 do the same two shifts on B.
- R8: `flag_zero` is 1 when A is zero. `flag_neg` is A[W-1]. `flag_norm` is 1 when A[W-1] differs from A[W-2]. `flag_carry` changes only on opcodes 7 and 8.
- R9: When `start` is low, `opcode` and `bus_in` have no effect. Opcode 0 with `start` changes no state and only produces `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Command pulse from the controller |
| opcode | input | 4 | Operation selected with `start` |
| bus_in | input | DATA_W | Shared bus data into the unit |
| done | output | 1 | Completion pulse, one cycle after `start` |
| bus_out | output | DATA_W | Register value driven toward the bus |
| bus_out_vld | output | 1 | `bus_out` carries a register value |
| flag_zero | output | 1 | Register A equals zero |
| flag_neg | output | 1 | Sign bit of register A |
| flag_norm | output | 1 | Top two bits of register A differ |
| flag_carry | output | 1 | Carry / no-borrow from the last add or subtract |

## Verification
The properties assume that `start` is low throughout reset. They also assume that `opcode` and `bus_in` are stable while they are sampled at a clock edge. Past-value checks therefore begin from a clean command history.

The bench follows these assumptions. It holds `start` low during reset and changes inputs only one nanosecond after a rising edge. Between commands it drives random opcodes and bus data with `start` low, so that the interface is exercised outside the assumed window as well.

// File: rtl/gpa_pkg.sv
`timescale 1ns/1ps
package gpa_pkg;

   // Operation codes issued together with the start pulse.
   typedef enum logic [3:0] {
      OP_NOP   = 4'd0,
      OP_MV_AB = 4'd1,   // B <- A
      OP_MV_BA = 4'd2,   // A <- B
      OP_LD_A  = 4'd3,
      OP_LD_B  = 4'd4,
      OP_OUT_A = 4'd5,
      OP_OUT_B = 4'd6,
      OP_ADD   = 4'd7,
      OP_SUB   = 4'd8,
      OP_NOT   = 4'd9,
      OP_AND   = 4'd10,
      OP_OR    = 4'd11,
      OP_SHL_A = 4'd12,
      OP_SHR_A = 4'd13,
      OP_SHL_B = 4'd14,
      OP_SHR_B = 4'd15
   } gpa_op_e;

   typedef enum logic [2:0] {
      FN_ADD = 3'd0,
      FN_SUB = 3'd1,
      FN_NOT = 3'd2,
      FN_AND = 3'd3,
      FN_OR  = 3'd4,
      FN_SHL = 3'd5,
      FN_SHR = 3'd6
   } gpa_fn_e;

   // Source selection for a register write.
   typedef enum logic [1:0] {
      SRC_BUS  = 2'd0,
      SRC_PEER = 2'd1,
      SRC_ALU  = 2'd2
   } gpa_src_e;

   typedef struct packed {
      logic     a_we;
      logic     b_we;
      gpa_src_e a_src;
      gpa_src_e b_src;
      logic     out_en;
      logic     out_b;
      logic     carry_we;
      logic     opnd_b;   // ALU first operand is B (shifts of B)
      gpa_fn_e  fn;
   } gpa_ctl_t;

endpackage

// File: rtl/gpa_decode.sv
`timescale 1ns/1ps
module gpa_decode
   import gpa_pkg::*;
(
   input  logic       start,
   input  logic [3:0] opcode,
   output gpa_ctl_t   ctl
);

   gpa_op_e op;
   assign op = gpa_op_e'(opcode);

   always_comb begin
      ctl = '0;
      ctl.a_src = SRC_ALU;
      ctl.b_src = SRC_ALU;
      ctl.fn    = FN_ADD;
      if (start) begin
         unique case (op)
            OP_NOP:   ;
            OP_MV_AB: begin ctl.b_we = 1'b1; ctl.b_src = SRC_PEER; end
            OP_MV_BA: begin ctl.a_we = 1'b1; ctl.a_src = SRC_PEER; end
            OP_LD_A:  begin ctl.a_we = 1'b1; ctl.a_src = SRC_BUS;  end
            OP_LD_B:  begin ctl.b_we = 1'b1; ctl.b_src = SRC_BUS;  end
            OP_OUT_A: ctl.out_en = 1'b1;
            OP_OUT_B: begin ctl.out_en = 1'b1; ctl.out_b = 1'b1; end
            OP_ADD:   begin ctl.a_we = 1'b1; ctl.carry_we = 1'b1; ctl.fn = FN_ADD; end
            OP_SUB:   begin ctl.a_we = 1'b1; ctl.carry_we = 1'b1; ctl.fn = FN_SUB; end
            OP_NOT:   begin ctl.a_we = 1'b1; ctl.fn = FN_NOT; end
            OP_AND:   begin ctl.a_we = 1'b1; ctl.fn = FN_AND; end
            OP_OR:    begin ctl.a_we = 1'b1; ctl.fn = FN_OR;  end
            OP_SHL_A: begin ctl.a_we = 1'b1; ctl.fn = FN_SHL; end
            OP_SHR_A: begin ctl.a_we = 1'b1; ctl.fn = FN_SHR; end
            OP_SHL_B: begin ctl.b_we = 1'b1; ctl.opnd_b = 1'b1; ctl.fn = FN_SHL; end
            OP_SHR_B: begin ctl.b_we = 1'b1; ctl.opnd_b = 1'b1; ctl.fn = FN_SHR; end
            default:  ;
         endcase
      end
   end

endmodule

// File: rtl/gpa_alu.sv
`timescale 1ns/1ps
module gpa_alu
   import gpa_pkg::*;
#(
   parameter int DATA_W     = 16,
   parameter int ADDER_MODE = 1    // 1: one shared adder, 0: separate add and subtract
) (
   input  logic [DATA_W-1:0] x,
   input  logic [DATA_W-1:0] y,
   input  gpa_fn_e           fn,
   output logic [DATA_W-1:0] res,
   output logic              carry
);

   localparam int MSB = DATA_W - 1;

   logic [DATA_W:0] sum_ext;

   if (ADDER_MODE == 1) begin : g_shared_adder
      logic            is_sub;
      logic [MSB:0]    y_eff;
      logic [DATA_W:0] cin_ext;
      assign is_sub  = (fn == FN_SUB);
      assign y_eff   = is_sub ? ~y : y;
      assign cin_ext = {{DATA_W{1'b0}}, is_sub};
      assign sum_ext = {1'b0, x} + {1'b0, y_eff} + cin_ext;
   end else begin : g_split_adder
      logic [DATA_W:0] add_ext;
      logic [DATA_W:0] sub_ext;
      assign add_ext = {1'b0, x} + {1'b0, y};
      assign sub_ext = {1'b0, x} + {1'b0, ~y} + {{DATA_W{1'b0}}, 1'b1};
      assign sum_ext = (fn == FN_SUB) ? sub_ext : add_ext;
   end

   always_comb begin
      unique case (fn)
         FN_ADD,
         FN_SUB:  res = sum_ext[MSB:0];
         FN_NOT:  res = ~x;
         FN_AND:  res = x & y;
         FN_OR:   res = x | y;
         FN_SHL:  res = {x[MSB-1:0], 1'b0};
         FN_SHR:  res = {x[MSB], x[MSB:1]};
         default: res = x;
      endcase
   end

   assign carry = sum_ext[DATA_W];

endmodule

// File: rtl/gpa_flags.sv
`timescale 1ns/1ps
module gpa_flags #(
   parameter int DATA_W = 16
) (
   input  logic [DATA_W-1:0] a_val,
   input  logic              carry_q,
   output logic              f_zero,
   output logic              f_neg,
   output logic              f_norm,
   output logic              f_carry
);

   localparam int MSB = DATA_W - 1;

   assign f_zero  = (a_val == '0);
   assign f_neg   = a_val[MSB];
   assign f_norm  = a_val[MSB] ^ a_val[MSB-1];
   assign f_carry = carry_q;

endmodule

// File: rtl/gpa_unit.sv
`timescale 1ns/1ps
module gpa_unit
   import gpa_pkg::*;
#(
   parameter int DATA_W     = 16,
   parameter int ADDER_MODE = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [3:0]        opcode,
   input  logic [DATA_W-1:0] bus_in,
   output logic              done,
   output logic [DATA_W-1:0] bus_out,
   output logic              bus_out_vld,
   output logic              flag_zero,
   output logic              flag_neg,
   output logic              flag_norm,
   output logic              flag_carry
);

   localparam int MSB = DATA_W - 1;

   if (DATA_W < 4) begin : g_bad_width
      $error("gpa_unit: DATA_W must be at least 4");
   end
   if (ADDER_MODE != 0 && ADDER_MODE != 1) begin : g_bad_adder
      $error("gpa_unit: ADDER_MODE must be 0 or 1");
   end

   logic [MSB:0] a_q, b_q, out_q;
   logic         c_q, done_q, vld_q;

   gpa_ctl_t     ctl;
   logic [MSB:0] alu_x, alu_res, a_nxt, b_nxt;
   logic         alu_c;

   gpa_decode u_dec (
      .start  (start),
      .opcode (opcode),
      .ctl    (ctl)
   );

   assign alu_x = ctl.opnd_b ? b_q : a_q;

   gpa_alu #(.DATA_W(DATA_W), .ADDER_MODE(ADDER_MODE)) u_alu (
      .x     (alu_x),
      .y     (b_q),
      .fn    (ctl.fn),
      .res   (alu_res),
      .carry (alu_c)
   );

   always_comb begin
      unique case (ctl.a_src)
         SRC_BUS:  a_nxt = bus_in;
         SRC_PEER: a_nxt = b_q;
         default:  a_nxt = alu_res;
      endcase
      unique case (ctl.b_src)
         SRC_BUS:  b_nxt = bus_in;
         SRC_PEER: b_nxt = a_q;
         default:  b_nxt = alu_res;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_q    <= '0;
         b_q    <= '0;
         c_q    <= 1'b0;
         done_q <= 1'b0;
         vld_q  <= 1'b0;
         out_q  <= '0;
      end else begin
         done_q <= start;
         vld_q  <= ctl.out_en;
         out_q  <= ctl.out_en ? (ctl.out_b ? b_q : a_q) : '0;
         if (ctl.a_we)     a_q <= a_nxt;
         if (ctl.b_we)     b_q <= b_nxt;
         if (ctl.carry_we) c_q <= alu_c;
      end
   end

   gpa_flags #(.DATA_W(DATA_W)) u_flags (
      .a_val   (a_q),
      .carry_q (c_q),
      .f_zero  (flag_zero),
      .f_neg   (flag_neg),
      .f_norm  (flag_norm),
      .f_carry (flag_carry)
   );

   assign done        = done_q;
   assign bus_out     = out_q;
   assign bus_out_vld = vld_q;

endmodule

// File: rtl/gpa_unit_chk.sv
`timescale 1ns/1ps
module gpa_unit_chk
   import gpa_pkg::*;
#(
   parameter int W = 16
) (
   input logic         clk,
   input logic         rst_n,
   input logic         start,
   input logic [3:0]   opcode,
   input logic [W-1:0] bus_in,
   input logic         done,
   input logic [W-1:0] bus_out,
   input logic         bus_out_vld,
   input logic         flag_zero,
   input logic         flag_neg,
   input logic         flag_norm,
   input logic         flag_carry
);

   AST_DONE_FOLLOWS_START: assert property (@(posedge clk) disable iff (!rst_n) start |=> done); // R2
   AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (!rst_n) !start |=> !done); // R2
   AST_BUS_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n) !bus_out_vld |-> (bus_out == '0)); // R4
   AST_VLD_FROM_OUT_OP: assert property (@(posedge clk) disable iff (!rst_n)
      bus_out_vld |-> $past(start && (opcode == OP_OUT_A || opcode == OP_OUT_B))); // R4
   AST_LOAD_A_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      (start && opcode == OP_LD_A) |=> (flag_zero == ($past(bus_in) == '0)) && (flag_neg == $past(bus_in[W-1]))); // R3
   AST_SUB_EQUAL_NO_BORROW: assert property (@(posedge clk) disable iff (!rst_n)
      (start && opcode == OP_SUB) |=> (!flag_zero || flag_carry)); // R5
   AST_CARRY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(start && (opcode == OP_ADD || opcode == OP_SUB)) |=> $stable(flag_carry)); // R8
   AST_NORM_NONZERO: assert property (@(posedge clk) disable iff (!rst_n) flag_norm |-> !flag_zero); // R8
   AST_IDLE_FLAGS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> ($stable(flag_zero) && $stable(flag_neg) && $stable(flag_norm))); // R9

endmodule

bind gpa_unit gpa_unit_chk #(.W(DATA_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start       (start),
   .opcode      (opcode),
   .bus_in      (bus_in),
   .done        (done),
   .bus_out     (bus_out),
   .bus_out_vld (bus_out_vld),
   .flag_zero   (flag_zero),
   .flag_neg    (flag_neg),
   .flag_norm   (flag_norm),
   .flag_carry  (flag_carry)
);

// File: tb/tb_gpa_unit.sv
`timescale 1ns/1ps
module tb_gpa_unit;

   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic [3:0]   opcode = '0;
   logic [W-1:0] bus_in = '0;
   logic         done, bus_out_vld, flag_zero, flag_neg, flag_norm, flag_carry;
   logic [W-1:0] bus_out;

   int errors = 0;
   int checks = 0;
   bit run = 1'b0;

   always #2.5 clk = ~clk;

   gpa_unit #(.DATA_W(W)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .bus_in(bus_in),
      .done(done), .bus_out(bus_out), .bus_out_vld(bus_out_vld),
      .flag_zero(flag_zero), .flag_neg(flag_neg), .flag_norm(flag_norm), .flag_carry(flag_carry)
   );

   // Reference model state
   logic [W-1:0] ma, mb, mout;
   logic         mc, mdone, mvld;
   string        mtag;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ma = '0; mb = '0; mc = 1'b0; mdone = 1'b0; mvld = 1'b0; mout = '0; mtag = "R1";
      end else begin
         logic [W:0] t;
         mdone = start; mvld = 1'b0; mout = '0;
         if (!start) mtag = "R9";
         else case (opcode)
            4'd0:  mtag = "R9";
            4'd1:  begin mb = ma; mtag = "R3"; end
            4'd2:  begin ma = mb; mtag = "R3"; end
            4'd3:  begin ma = bus_in; mtag = "R3"; end
            4'd4:  begin mb = bus_in; mtag = "R3"; end
            4'd5:  begin mout = ma; mvld = 1'b1; mtag = "R4"; end
            4'd6:  begin mout = mb; mvld = 1'b1; mtag = "R4"; end
            4'd7:  begin t = {1'b0, ma} + {1'b0, mb}; ma = t[W-1:0]; mc = t[W]; mtag = "R5"; end
            4'd8:  begin mc = (ma >= mb); ma = ma - mb; mtag = "R5"; end
            4'd9:  begin ma = ~ma; mtag = "R6"; end
            4'd10: begin ma = ma & mb; mtag = "R6"; end
            4'd11: begin ma = ma | mb; mtag = "R6"; end
            4'd12: begin ma = ma << 1; mtag = "R7"; end
            4'd13: begin ma = W'($signed(ma) >>> 1); mtag = "R7"; end
            4'd14: begin mb = mb << 1; mtag = "R7"; end
            default: begin mb = W'($signed(mb) >>> 1); mtag = "R7"; end
         endcase
      end
   end

   task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", what, act, exp, $time);
      end
   endtask

   // Compare against the model on every falling edge.
   always @(negedge clk) begin
      if (rst_n && run) begin
         chk(done === mdone, "R2 done", 32'(done), 32'(mdone));
         chk(bus_out_vld === mvld, "R4 valid", 32'(bus_out_vld), 32'(mvld));
         chk(bus_out === mout, "R4 bus_out", 32'(bus_out), 32'(mout));
         chk(flag_zero === (ma == '0), {mtag, "/R8 zero"}, 32'(flag_zero), 32'(ma == '0));
         chk(flag_neg === ma[W-1], {mtag, "/R8 neg"}, 32'(flag_neg), 32'(ma[W-1]));
         chk(flag_norm === (ma[W-1] ^ ma[W-2]), {mtag, "/R8 norm"}, 32'(flag_norm), 32'(ma[W-1] ^ ma[W-2]));
         chk(flag_carry === mc, {mtag, "/R8 carry"}, 32'(flag_carry), 32'(mc));
      end
   end

   task automatic issue(input logic [3:0] op, input logic [W-1:0] d);
      start = 1'b1; opcode = op; bus_in = d;
      @(posedge clk); #1;
      start = 1'b0; opcode = 4'($urandom); bus_in = W'($urandom);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         start = 1'b0; opcode = 4'($urandom); bus_in = W'($urandom);
         @(posedge clk); #1;
      end
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      #(200000 * 5);
      checks++; errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state seen at the ports
      chk(done === 1'b0 && bus_out_vld === 1'b0, "R1 handshake idle", 32'({done, bus_out_vld}), 0);
      chk(bus_out === '0, "R1 bus_out zero", 32'(bus_out), 0);
      chk(flag_zero === 1'b1 && flag_carry === 1'b0, "R1 flags", 32'({flag_zero, flag_carry}), 32'h2);
      run = 1'b1;
      @(posedge clk); #1;
      issue(4'd5, '0);               // R4 A after reset
      issue(4'd6, '0);
      issue(4'd3, 16'h1234);         // R3 loads
      issue(4'd4, 16'h00FF);
      issue(4'd5, '0);
      issue(4'd6, '0);
      issue(4'd7, '0);               // R5 add
      issue(4'd5, '0);
      issue(4'd8, '0);               // R5 sub back
      issue(4'd3, 16'hFFFF);         // R5 carry out with zero result
      issue(4'd4, 16'h0001);
      issue(4'd7, '0);
      issue(4'd8, '0);               // R5 borrow: 0 - 1
      issue(4'd3, 16'h0005);
      issue(4'd4, 16'h0005);
      issue(4'd8, '0);               // R5 equal operands
      idle(4);                       // R9 junk with start low
      issue(4'd3, 16'h8001);         // R7 shifts
      issue(4'd12, '0);
      issue(4'd3, 16'h8001);
      issue(4'd13, '0);
      issue(4'd5, '0);
      issue(4'd4, 16'h4000);
      issue(4'd15, '0);
      issue(4'd14, '0);
      issue(4'd14, '0);
      issue(4'd6, '0);
      issue(4'd9, '0);               // R6 logic
      issue(4'd10, '0);
      issue(4'd11, '0);
      issue(4'd1, '0);               // R3 moves
      issue(4'd3, 16'h0F0F);
      issue(4'd2, '0);
      issue(4'd6, '0);
      issue(4'd0, 16'hFFFF);         // R9 no-op
      issue(4'd5, '0);
      for (int k = 0; k < 600; k++) begin
         if ($urandom_range(0, 5) == 0) idle($urandom_range(1, 3));
         issue(4'($urandom), W'($urandom));
      end
      idle(3);
      run = 1'b0;
      finish_run();
   end

endmodule